// File: doc/BRIEF.md
# Dual-Mode Per-Processor Timer

This block is the timer that belongs to one processor. It runs in one of two modes, chosen by a mode bit that a shared mode register outside the block supplies. In counter mode it is a limit-compare timer. A programmable limit sets the length of its period. When the count reaches the limit, the count restarts from zero, a reached flag is set and an interrupt is raised. Reading the limit word clears both the flag and the interrupt.

In user mode the same four word slots take a different meaning. The block becomes a 54-bit free-running counter that never interrupts. Software preloads the count through a high word and a low word, and starts or stops it through a run word. Each count unit is worth 0x200 in the word view, so the low 9 bits of every count word read as zero. A single-cycle `tick` pulse advances the count by one unit; in the target system it arrives every 500 ns.

Register access is a plain one-access-per-cycle strobe interface with no back-pressure. Every read is answered exactly one cycle later, with `rd_valid` high, so the reader never has to wait or stall.

Top module: `dpt_timer`

## Requirements
- R1: After reset the block is in counter mode with running = 1, count 0, limit 0, reached 0 and `irq` low. Reading word 1 returns 0, word 0 returns 0 and word 3 returns 1.
- R2: In counter mode each `tick` adds 0x200 to the count. A read of word 1 returns the reached flag in bit 31 and the count in bits 30:9.
- R3: In counter mode, writing word 0 loads the limit from bits 30:9, resets the count to 0 and lowers `irq`. With a nonzero limit L, the tick that would make the count L instead makes it 0, sets the reached flag and raises `irq`.
- R4: In counter mode, reading word 0 returns the limit in bits 30:9 and clears both reached and `irq`. With limit 0 the counter runs freely and never sets reached or `irq`.
- R5: In counter mode, writing word 2 loads the limit without touching the count. Writes to word 1 and word 3 change nothing.
- R6: A mode strobe that moves the block into user mode lowers `irq`, stops counting (running = 0), and clears the count and the reached flag.
- R7: In user mode, word 0 reads {reached, count bits 53:23}. Writing word 0 loads count bits 53:23 from data bits 30:0. Word 1 reads {count bits 22:0, 9 zero bits}. Writing word 1 loads count bits 22:0 from data bits 31:9. Either write clears reached, takes effect in the next cycle and leaves the running state as it was.
- R8: In user mode, a write to word 3 with bit 0 = 1 starts the counter and a write with bit 0 = 0 stops it. A write that matches the current state changes nothing. Word 3 always reads the running flag in bit 0.
- R9: In user mode the count advances only while running. The low word carries into the high word. At the all-ones count a tick wraps the count to 0 and sets reached, and `irq` stays low throughout.
- R10: A mode strobe that returns the block to counter mode sets running = 1 and clears the count, the limit (free-run) and reached.
- R11: A read is answered with `rd_valid` high one cycle later, with data taken from the state before that edge. A mode strobe that changes the mode overrides any access or tick in the same cycle. A strobe that repeats the current mode does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse that advances the count by one unit |
| mode_user | input | 1 | Requested mode: 1 selects user mode, 0 selects counter mode |
| mode_chg | input | 1 | Strobe: apply mode_user in this cycle |
| acc_en | input | 1 | Register access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read (valid with acc_en) |
| acc_addr | input | 2 | Word slot 0..3 |
| acc_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | High one cycle after a read access |
| irq | output | 1 | Counter-mode limit interrupt, level |

## Verification
The assertions rely on the following about the inputs:
- `mode_user` matters only in a cycle where `mode_chg` is high.
- At most one access arrives per cycle.
- `tick` is a clean single-cycle pulse.

The bench drives every input at the falling edge and holds each one for exactly one cycle. Only the precedence cases raise a mode strobe together with a tick or an access. Expected count words are computed arithmetically for a sweep of small limits, across several preload offsets around the low-to-high carry, and at the all-ones user count.

// File: rtl/dpt_pkg.sv
package dpt_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned FRAC_W  = 9;                 // fixed-zero low bits of every count word
  localparam int unsigned CMP_W   = 22;                // counter-mode unit bits (word bits 30:9)
  localparam int unsigned LOW_P_W = WORD_W - FRAC_W;   // user-mode unit bits in the low word
  localparam int unsigned HIGH_W  = 31;                // user-mode bits in the high word
  localparam int unsigned USR_W   = LOW_P_W + HIGH_W;  // full user count width (54)

  typedef enum logic [1:0] {
    SLOT_LIM      = 2'd0,
    SLOT_CNT      = 2'd1,
    SLOT_LIM_KEEP = 2'd2,
    SLOT_RUN      = 2'd3
  } slot_e;

  typedef struct packed {
    logic              rd;
    logic              wr;
    slot_e             slot;
    logic [WORD_W-1:0] data;
  } acc_t;
endpackage

// File: rtl/dpt_mode_ctrl.sv
module dpt_mode_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_user,
  input  logic mode_chg,
  input  logic run_wr,
  input  logic run_val,
  output logic user_q,
  output logic run_q,
  output logic go_user,
  output logic go_cnt
);
  assign go_user = mode_chg &  mode_user & ~user_q;
  assign go_cnt  = mode_chg & ~mode_user &  user_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      user_q <= 1'b0;
      run_q  <= 1'b1;
    end else if (go_user) begin
      user_q <= 1'b1;
      run_q  <= 1'b0;
    end else if (go_cnt) begin
      user_q <= 1'b0;
      run_q  <= 1'b1;
    end else if (user_q && run_wr) begin
      run_q <= run_val;
    end
  end

  // R1
  cnt_mode_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !user_q |-> run_q);
  // R6
  enter_user_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_user |=> (user_q && !run_q));
  // R10
  enter_cnt_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_cnt |=> (!user_q && run_q));
  // R11
  same_mode_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_chg && (mode_user == user_q)) |=> (user_q == $past(user_q)));
endmodule

// File: rtl/dpt_counter.sv
module dpt_counter
  import dpt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             user_q,
  input  logic             run_q,
  input  logic             go_user,
  input  logic             go_cnt,
  input  acc_t             acc,
  output logic [USR_W-1:0] cnt_q,
  output logic [CMP_W-1:0] lim_q,
  output logic             reached_q,
  output logic             irq_q
);
  localparam logic [CMP_W-1:0] CMP_FREE_TOP = '1;
  localparam logic [USR_W-1:0] USR_TOP      = '1;

  logic [USR_W-1:0] cnt_d;
  logic [CMP_W-1:0] lim_d;
  logic             rch_d, irq_d;
  logic [CMP_W-1:0] cmp_inc, cmp_top;
  logic             wr_lim, wr_cnt, wr_keep, rd_lim;

  assign cmp_inc = cnt_q[CMP_W-1:0] + 1'b1;
  assign cmp_top = (lim_q == '0) ? CMP_FREE_TOP : lim_q;
  assign wr_lim  = acc.wr && (acc.slot == SLOT_LIM);
  assign wr_cnt  = acc.wr && (acc.slot == SLOT_CNT);
  assign wr_keep = acc.wr && (acc.slot == SLOT_LIM_KEEP);
  assign rd_lim  = acc.rd && (acc.slot == SLOT_LIM);

  always_comb begin
    cnt_d = cnt_q;
    lim_d = lim_q;
    rch_d = reached_q;
    irq_d = irq_q;
    if (go_user) begin
      cnt_d = '0;
      rch_d = 1'b0;
      irq_d = 1'b0;
    end else if (go_cnt) begin
      cnt_d = '0;
      lim_d = '0;
      rch_d = 1'b0;
      irq_d = 1'b0;
    end else if (user_q) begin
      if (wr_lim) begin
        cnt_d[USR_W-1:LOW_P_W] = acc.data[HIGH_W-1:0];
        rch_d = 1'b0;
      end else if (wr_cnt) begin
        cnt_d[LOW_P_W-1:0] = acc.data[WORD_W-1:FRAC_W];
        rch_d = 1'b0;
      end else if (tick && run_q) begin
        if (cnt_q == USR_TOP) begin
          cnt_d = '0;
          rch_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end else begin
      if (rd_lim) begin
        rch_d = 1'b0;
        irq_d = 1'b0;
      end
      if (wr_lim) begin
        lim_d = acc.data[FRAC_W+CMP_W-1:FRAC_W];
        cnt_d = '0;
        irq_d = 1'b0;
      end else begin
        if (wr_keep) lim_d = acc.data[FRAC_W+CMP_W-1:FRAC_W];
        if (tick) begin
          if (cmp_inc == cmp_top) begin
            cnt_d = '0;
            if (lim_q != '0) begin
              rch_d = 1'b1;
              irq_d = 1'b1;
            end
          end else begin
            cnt_d = {{(USR_W-CMP_W){1'b0}}, cmp_inc};
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      lim_q     <= '0;
      reached_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      lim_q     <= lim_d;
      reached_q <= rch_d;
      irq_q     <= irq_d;
    end
  end

  // R9
  user_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    user_q |-> !irq_q);
  // R3
  irq_has_reached_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> reached_q);
  // R9
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (user_q && !run_q && !acc.wr && !go_cnt) |=> $stable(cnt_q));
  // R4
  free_run_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!user_q && !go_user && !go_cnt && (lim_q == '0) && !reached_q && !wr_lim && !wr_keep)
      |=> !reached_q);
  // R6
  enter_user_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_user |=> (cnt_q == '0 && !reached_q && !irq_q));
endmodule

// File: rtl/dpt_readback.sv
module dpt_readback
  import dpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  slot_e             slot,
  input  logic              user_q,
  input  logic              run_q,
  input  logic [USR_W-1:0]  cnt_q,
  input  logic [CMP_W-1:0]  lim_q,
  input  logic              reached_q,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid
);
  logic [WORD_W-1:0] word;

  always_comb begin
    unique case (slot)
      SLOT_LIM: word = user_q ? {reached_q, cnt_q[USR_W-1:LOW_P_W]}
                              : {1'b0, lim_q, {FRAC_W{1'b0}}};
      SLOT_CNT: word = user_q ? {cnt_q[LOW_P_W-1:0], {FRAC_W{1'b0}}}
                              : {reached_q, cnt_q[CMP_W-1:0], {FRAC_W{1'b0}}};
      SLOT_RUN: word = {{(WORD_W-1){1'b0}}, run_q};
      default:  word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= word;
    end
  end

  // R11
  rd_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  // R11
  rd_no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
endmodule

// File: rtl/dpt_timer.sv
module dpt_timer
  import dpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              mode_user,
  input  logic              mode_chg,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [1:0]        acc_addr,
  input  logic [WORD_W-1:0] acc_wdata,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              irq
);
  acc_t             acc;
  logic             user_q, run_q, go_user, go_cnt;
  logic [USR_W-1:0] cnt_q;
  logic [CMP_W-1:0] lim_q;
  logic             reached_q;

  always_comb begin
    acc.rd   = acc_en & ~acc_wr;
    acc.wr   = acc_en &  acc_wr;
    acc.slot = slot_e'(acc_addr);
    acc.data = acc_wdata;
  end

  dpt_mode_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_user(mode_user),
    .mode_chg (mode_chg),
    .run_wr   (acc.wr && (acc.slot == SLOT_RUN)),
    .run_val  (acc_wdata[0]),
    .user_q   (user_q),
    .run_q    (run_q),
    .go_user  (go_user),
    .go_cnt   (go_cnt)
  );

  dpt_counter u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .user_q   (user_q),
    .run_q    (run_q),
    .go_user  (go_user),
    .go_cnt   (go_cnt),
    .acc      (acc),
    .cnt_q    (cnt_q),
    .lim_q    (lim_q),
    .reached_q(reached_q),
    .irq_q    (irq)
  );

  dpt_readback u_rb (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (acc.rd),
    .slot     (acc.slot),
    .user_q   (user_q),
    .run_q    (run_q),
    .cnt_q    (cnt_q),
    .lim_q    (lim_q),
    .reached_q(reached_q),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );
endmodule

// File: tb/dpt_timer_tb.sv
module dpt_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, mode_user = 1'b0, mode_chg = 1'b0;
  logic        acc_en = 1'b0, acc_wr = 1'b0;
  logic [1:0]  acc_addr = 2'd0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] rd_data;
  logic        rd_valid, irq;
  int          nchk = 0, nfail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  dpt_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode_user(mode_user), .mode_chg(mode_chg),
    .acc_en(acc_en), .acc_wr(acc_wr), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .rd_data(rd_data), .rd_valid(rd_valid), .irq(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_tick(int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    acc_en = 1'b1; acc_wr = 1'b1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0;
  endtask

  task automatic rdchk(string tag, logic [1:0] a, logic [31:0] exp);
    acc_en = 1'b1; acc_wr = 1'b0; acc_addr = a;
    @(negedge clk);
    acc_en = 1'b0;
    chk({tag, " rd_valid"}, {31'd0, rd_valid}, 32'd1);
    chk(tag, rd_data, exp);
  endtask

  task automatic set_mode(logic u);
    mode_user = u; mode_chg = 1'b1;
    @(negedge clk);
    mode_chg = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      nchk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    rdchk("R1 word1", 2'd1, 32'h0);
    rdchk("R1 word0", 2'd0, 32'h0);
    rdchk("R1 word3", 2'd3, 32'h1);

    // R2 free counting
    do_tick(5);
    rdchk("R2 count", 2'd1, 32'h0000_0A00);

    // R3 / R4 sweep of small limits
    for (int lim = 1; lim <= 6; lim++) begin
      wr(2'd0, 32'(lim) << 9);
      for (int k = 1; k <= 2 * lim + 1; k++) begin
        do_tick(1);
        rdchk("R3 count", 2'd1, ((k >= lim) ? 32'h8000_0000 : 32'h0) | (32'(k % lim) << 9));
        chk("R3 irq", {31'd0, irq}, (k >= lim) ? 32'd1 : 32'd0);
      end
      rdchk("R4 limit read", 2'd0, 32'(lim) << 9);
      chk("R4 irq cleared", {31'd0, irq}, 32'd0);
      rdchk("R4 reached cleared", 2'd1, 32'((2 * lim + 1) % lim) << 9);
    end

    // R5 limit without count reset
    wr(2'd0, 32'd4 << 9);
    do_tick(2);
    wr(2'd2, 32'd10 << 9);
    rdchk("R5 count kept", 2'd1, 32'h400);
    do_tick(8);
    rdchk("R5 new limit hit", 2'd1, 32'h8000_0000);
    rdchk("R5 limit read", 2'd0, 32'd10 << 9);
    wr(2'd1, 32'h1234_5600);
    rdchk("R5 word1 write ignored", 2'd1, 32'h0);
    wr(2'd3, 32'h0);
    rdchk("R5 word3 write ignored", 2'd3, 32'h1);

    // R4 free run
    wr(2'd0, 32'h0);
    do_tick(3);
    rdchk("R4 free run", 2'd1, 32'h600);
    chk("R4 free run irq", {31'd0, irq}, 32'd0);

    // R6 enter user mode
    wr(2'd0, 32'd2 << 9);
    do_tick(2);
    chk("R3 irq before switch", {31'd0, irq}, 32'd1);
    set_mode(1'b1);
    chk("R6 irq lowered", {31'd0, irq}, 32'd0);
    rdchk("R6 stopped", 2'd3, 32'h0);
    rdchk("R6 high", 2'd0, 32'h0);
    rdchk("R6 low", 2'd1, 32'h0);
    do_tick(3);
    rdchk("R9 stopped no count", 2'd1, 32'h0);

    // R7 word formats, R8 run control, R9 max wrap
    wr(2'd0, 32'hFFFF_FFFF);
    rdchk("R7 high masked", 2'd0, 32'h7FFF_FFFF);
    wr(2'd1, 32'hFFFF_FFFF);
    rdchk("R7 low", 2'd1, 32'hFFFF_FE00);
    rdchk("R7 run unchanged", 2'd3, 32'h0);
    wr(2'd3, 32'h1);
    rdchk("R8 started", 2'd3, 32'h1);
    do_tick(1);
    rdchk("R9 wrap low", 2'd1, 32'h0);
    rdchk("R9 wrap reached", 2'd0, 32'h8000_0000);
    chk("R9 no irq", {31'd0, irq}, 32'd0);
    wr(2'd1, 32'h0);
    rdchk("R7 reached cleared", 2'd0, 32'h0);

    // R9 carry sweep
    for (int hi = 0; hi < 3; hi++) begin
      for (int j = 0; j < 4; j++) begin
        logic [31:0] hv;
        hv = (hi == 0) ? 32'h0 : ((hi == 1) ? 32'h5 : 32'h1234);
        wr(2'd0, hv);
        wr(2'd1, 32'hFFFF_FE00 - (32'(j) << 9));
        do_tick(j + 2);
        rdchk("R9 carry low", 2'd1, 32'h200);
        rdchk("R9 carry high", 2'd0, hv + 32'd1);
      end
    end

    // R8 stop and idempotent writes
    wr(2'd3, 32'h0);
    do_tick(4);
    rdchk("R8 stopped hold", 2'd1, 32'h200);
    wr(2'd3, 32'hFFFF_FFFE);
    rdchk("R8 repeated stop", 2'd3, 32'h0);
    wr(2'd3, 32'h1);
    wr(2'd3, 32'h1);
    rdchk("R8 repeated start", 2'd3, 32'h1);

    // R11 repeated mode strobe
    set_mode(1'b1);
    rdchk("R11 same mode keeps run", 2'd3, 32'h1);
    rdchk("R11 same mode keeps count", 2'd1, 32'h200);

    // R10 leave user mode
    set_mode(1'b0);
    rdchk("R10 running", 2'd3, 32'h1);
    rdchk("R10 limit", 2'd0, 32'h0);
    rdchk("R10 count", 2'd1, 32'h0);
    do_tick(2);
    rdchk("R10 counts", 2'd1, 32'h400);

    // R11 precedence of a mode change
    mode_user = 1'b1; mode_chg = 1'b1; tick = 1'b1;
    @(negedge clk);
    mode_chg = 1'b0; tick = 1'b0;
    rdchk("R11 tick overridden", 2'd1, 32'h0);
    rdchk("R11 user stopped", 2'd3, 32'h0);
    mode_user = 1'b0; mode_chg = 1'b1;
    acc_en = 1'b1; acc_wr = 1'b1; acc_addr = 2'd3; acc_wdata = 32'h0;
    @(negedge clk);
    mode_chg = 1'b0; acc_en = 1'b0; acc_wr = 1'b0;
    chk("R11 no response to write", {31'd0, rd_valid}, 32'd0);
    rdchk("R11 write overridden", 2'd3, 32'h1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule